// File: doc/BRIEF.md
# Multi-core external interrupt router

This block takes a bank of level-sensitive interrupt sources, organised in groups of 32, and steers each one to one CPU out of a set of CPUs. Every CPU has four interrupt output pins. Each source has an enable bit and a target-core byte. Each group of 32 sources has a pin-select byte. When an enabled source rises, the block records it in the in-service register of its target core. A CPU's pin is high while at least one in-service source that maps to that pin remains.

Software reaches the block through a single-cycle 32-bit word port that carries a requester ID. The in-service view and its write-1-to-clear acknowledge act on the copy of the CPU that is making the access. All other registers are shared between the CPUs. A write that changes an enable word or a target-core byte replays the sources that are already pending. A newly enabled source is raised, a newly disabled source is withdrawn, and a retargeted source moves from its old core to its new core. The bounce and node-type words are storage only and have no effect on routing.

Top module: `xirq_router`

## Requirements
- R1: The raw pending bit of each source copies that source's input level at every clock edge, whether or not the source is enabled. Raw group g reads at word offset 0x040+g, and source s sits in word s/32 at bit s%32.
- R2: A rise on an enabled source sets its in-service bit at its target core, and that core's pin goes high after the same edge. A rise on a disabled source changes no in-service bit and no pin.
- R3: A fall clears the source's in-service bit. The pin stays high while another in-service source of that core maps to the same pin.
- R4: Pin-select byte g%4 of word 0x0C0+g/4 serves group g. The lowest set bit among bits 0..3 gives the pin. A byte with none of bits 0..3 set selects pin 0. Output irq_o[c*4+p] is pin p of core c.
- R5: Core byte s%4 of word 0x100+s/4 serves source s and is decoded the same way as the pin byte. An index at or above the CPU count gives core 0. The written word reads back unchanged.
- R6: A write to enable word 0x000+g raises each newly enabled source whose raw bit is 1 and withdraws each newly disabled source whose raw bit is 1.
- R7: A write to in-service word 0x080+g clears the requester's bits wherever wdata is 1. It leaves the copies of other CPUs alone. A source that stays high is not raised again.
- R8: A read of in-service word 0x080+g returns the requester's copy. While read enable is low, rdata is zero.
- R9: Retargeting a pending source withdraws it from the old core and raises it at the new core if it is enabled. For a source that is not pending, the write only updates the map.
- R10: Bounce words 0x200+g and node-type words 0x240+n read back what was written and leave the pins unchanged.
- R11: Reset clears all state, so every pin is low and every register reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | N_SRC | Interrupt source levels |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| off_i | input | 12 | Word offset |
| wdata_i | input | 32 | Write data |
| req_id_i | input | CPU_W | Requesting CPU |
| rdata_o | output | 32 | Read data, combinational |
| irq_o | output | N_CPU*4 | Per-core pins, index core*4+pin |

## Verification
A change on a source, or a register write, takes effect in state one clock edge later. The pins are decoded straight from that state, so they are due right after the same edge. The bench drives its inputs on the falling edge and samples the pins on the next falling edge, which puts exactly one rising edge in between. Reads are combinational. The bench therefore samples rdata shortly after it sets rd_en, with no clock edge in between, so a read never observes an update it did not cause.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned N_PIN = 4;
  localparam int unsigned DEC_SPAN = 4;
  localparam int unsigned OFF_W = 12;
  localparam logic [OFF_W-1:0] EN_BASE  = 12'h000;
  localparam logic [OFF_W-1:0] RAW_BASE = 12'h040;
  localparam logic [OFF_W-1:0] ISR_BASE = 12'h080;
  localparam logic [OFF_W-1:0] PM_BASE  = 12'h0C0;
  localparam logic [OFF_W-1:0] CM_BASE  = 12'h100;
  localparam logic [OFF_W-1:0] BO_BASE  = 12'h200;
  localparam logic [OFF_W-1:0] ND_BASE  = 12'h240;

  function automatic logic in_win(logic [OFF_W-1:0] off, logic [OFF_W-1:0] base,
                                  int unsigned n);
    return (off >= base) && ((off - base) < OFF_W'(n));
  endfunction
endpackage

// File: rtl/xirq_byte_dec.sv
module xirq_byte_dec #(
  parameter int unsigned N_OUT = 4,
  parameter int unsigned OUT_W = 2
) (
  input  logic [7:0]       byte_i,
  output logic [OUT_W-1:0] idx_o
);
  import xirq_pkg::*;

  always_comb begin
    int lo;
    logic found;
    lo = 0;
    found = 1'b0;
    for (int i = DEC_SPAN - 1; i >= 0; i--) begin
      if (byte_i[i]) begin
        lo = i;
        found = 1'b1;
      end
    end
    idx_o = (found && lo < int'(N_OUT)) ? OUT_W'(lo) : '0;
  end
endmodule

// File: rtl/xirq_src_slice.sv
module xirq_src_slice #(
  parameter int unsigned N_CPU = 4,
  parameter int unsigned CPU_W = 2
) (
  input  logic             src_i,
  input  logic             raw_q_i,
  input  logic             en_q_i,
  input  logic             en_wr_i,
  input  logic             en_new_i,
  input  logic             core_wr_i,
  input  logic [CPU_W-1:0] core_old_i,
  input  logic [CPU_W-1:0] core_new_i,
  input  logic             w1c_i,
  input  logic [CPU_W-1:0] req_i,
  input  logic [N_CPU-1:0] col_q_i,
  output logic             en_d_o,
  output logic [N_CPU-1:0] col_d_o
);
  logic [CPU_W-1:0] c_cur;

  // Order: enable replay, retarget, acknowledge, then source edge.
  always_comb begin
    col_d_o = col_q_i;
    en_d_o  = en_wr_i ? en_new_i : en_q_i;
    c_cur   = core_wr_i ? core_new_i : core_old_i;
    if (en_wr_i && raw_q_i) begin
      if (en_new_i && !en_q_i) col_d_o[core_old_i] = 1'b1;
      if (!en_new_i && en_q_i) col_d_o[core_old_i] = 1'b0;
    end
    if (core_wr_i && raw_q_i && (core_new_i != core_old_i)) begin
      col_d_o[core_old_i] = 1'b0;
      if (en_d_o) col_d_o[core_new_i] = 1'b1;
    end
    if (w1c_i) begin
      for (int c = 0; c < int'(N_CPU); c++)
        if (CPU_W'(c) == req_i) col_d_o[c] = 1'b0;
    end
    if (src_i && !raw_q_i && en_d_o) col_d_o[c_cur] = 1'b1;
    if (!src_i && raw_q_i) col_d_o[c_cur] = 1'b0;
  end
endmodule

// File: rtl/xirq_pin_agg.sv
module xirq_pin_agg #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 4
) (
  input  logic [N_CPU-1:0][N_SRC-1:0]      isr_i,
  input  logic [N_SRC/32-1:0][1:0]         pin_of_grp_i,
  output logic [N_CPU*xirq_pkg::N_PIN-1:0] irq_o
);
  import xirq_pkg::*;

  logic [N_PIN-1:0][N_SRC-1:0] pin_mask;

  for (genvar p = 0; p < N_PIN; p++) begin : g_mask
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      assign pin_mask[p][s] = (pin_of_grp_i[s/32] == 2'(p));
    end
  end

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    for (genvar p = 0; p < N_PIN; p++) begin : g_pin
      assign irq_o[c*N_PIN+p] = |(isr_i[c] & pin_mask[p]);
    end
  end
endmodule

// File: rtl/xirq_router.sv
module xirq_router
  import xirq_pkg::*;
#(
  parameter int unsigned N_SRC  = 64,
  parameter int unsigned N_CPU  = 4,
  parameter int unsigned N_NODE = 8,
  localparam int unsigned CPU_W = (N_CPU > 1) ? $clog2(N_CPU) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [N_SRC-1:0]       src_i,
  input  logic                   wr_en_i,
  input  logic                   rd_en_i,
  input  logic [OFF_W-1:0]       off_i,
  input  logic [31:0]            wdata_i,
  input  logic [CPU_W-1:0]       req_id_i,
  output logic [31:0]            rdata_o,
  output logic [N_CPU*N_PIN-1:0] irq_o
);
  localparam int unsigned N_GRP = N_SRC / 32;
  localparam int unsigned N_PMW = (N_GRP + 3) / 4;
  localparam int unsigned N_CMW = N_SRC / 4;

  logic [N_SRC-1:0] raw_q, en_q, en_d;
  logic [N_CPU-1:0][N_SRC-1:0] isr_q, isr_d;
  logic [31:0] pmap_q [N_PMW];
  logic [31:0] cmap_q [N_CMW];
  logic [31:0] bnc_q  [N_GRP];
  logic [31:0] node_q [N_NODE];

  logic [N_SRC-1:0][CPU_W-1:0] core_idx, core_new;
  logic [N_GRP-1:0][1:0]       pin_of_grp;
  logic [N_SRC-1:0][N_CPU-1:0] col_q, col_d;

  logic en_hit, raw_hit, isr_hit, pm_hit, cm_hit, bo_hit, nd_hit;
  logic [OFF_W-1:0] en_rel, raw_rel, isr_rel, pm_rel, cm_rel, bo_rel, nd_rel;

  assign en_hit  = in_win(off_i, EN_BASE,  N_GRP);
  assign raw_hit = in_win(off_i, RAW_BASE, N_GRP);
  assign isr_hit = in_win(off_i, ISR_BASE, N_GRP);
  assign pm_hit  = in_win(off_i, PM_BASE,  N_PMW);
  assign cm_hit  = in_win(off_i, CM_BASE,  N_CMW);
  assign bo_hit  = in_win(off_i, BO_BASE,  N_GRP);
  assign nd_hit  = in_win(off_i, ND_BASE,  N_NODE);
  assign en_rel  = off_i - EN_BASE;
  assign raw_rel = off_i - RAW_BASE;
  assign isr_rel = off_i - ISR_BASE;
  assign pm_rel  = off_i - PM_BASE;
  assign cm_rel  = off_i - CM_BASE;
  assign bo_rel  = off_i - BO_BASE;
  assign nd_rel  = off_i - ND_BASE;

  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    xirq_byte_dec #(.N_OUT(N_PIN), .OUT_W(2)) u_pdec (
      .byte_i(pmap_q[g/4][8*(g%4) +: 8]),
      .idx_o (pin_of_grp[g])
    );
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_src
    xirq_byte_dec #(.N_OUT(N_CPU), .OUT_W(CPU_W)) u_cdec_q (
      .byte_i(cmap_q[s/4][8*(s%4) +: 8]),
      .idx_o (core_idx[s])
    );
    xirq_byte_dec #(.N_OUT(N_CPU), .OUT_W(CPU_W)) u_cdec_w (
      .byte_i(wdata_i[8*(s%4) +: 8]),
      .idx_o (core_new[s])
    );
    for (genvar c = 0; c < N_CPU; c++) begin : g_col
      assign col_q[s][c] = isr_q[c][s];
      assign isr_d[c][s] = col_d[s][c];
    end
    xirq_src_slice #(.N_CPU(N_CPU), .CPU_W(CPU_W)) u_slice (
      .src_i     (src_i[s]),
      .raw_q_i   (raw_q[s]),
      .en_q_i    (en_q[s]),
      .en_wr_i   (wr_en_i && en_hit && en_rel == OFF_W'(s/32)),
      .en_new_i  (wdata_i[s%32]),
      .core_wr_i (wr_en_i && cm_hit && cm_rel == OFF_W'(s/4)),
      .core_old_i(core_idx[s]),
      .core_new_i(core_new[s]),
      .w1c_i     (wr_en_i && isr_hit && isr_rel == OFF_W'(s/32) && wdata_i[s%32]),
      .req_i     (req_id_i),
      .col_q_i   (col_q[s]),
      .en_d_o    (en_d[s]),
      .col_d_o   (col_d[s])
    );
  end

  xirq_pin_agg #(.N_SRC(N_SRC), .N_CPU(N_CPU)) u_agg (
    .isr_i       (isr_q),
    .pin_of_grp_i(pin_of_grp),
    .irq_o       (irq_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      isr_q <= '0;
      for (int w = 0; w < int'(N_PMW); w++) pmap_q[w] <= '0;
      for (int w = 0; w < int'(N_CMW); w++) cmap_q[w] <= '0;
      for (int w = 0; w < int'(N_GRP); w++) bnc_q[w] <= '0;
      for (int w = 0; w < int'(N_NODE); w++) node_q[w] <= '0;
    end else begin
      raw_q <= src_i;
      en_q  <= en_d;
      isr_q <= isr_d;
      if (wr_en_i) begin
        for (int w = 0; w < int'(N_PMW); w++)
          if (pm_hit && pm_rel == OFF_W'(w)) pmap_q[w] <= wdata_i;
        for (int w = 0; w < int'(N_CMW); w++)
          if (cm_hit && cm_rel == OFF_W'(w)) cmap_q[w] <= wdata_i;
        for (int w = 0; w < int'(N_GRP); w++)
          if (bo_hit && bo_rel == OFF_W'(w)) bnc_q[w] <= wdata_i;
        for (int w = 0; w < int'(N_NODE); w++)
          if (nd_hit && nd_rel == OFF_W'(w)) node_q[w] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (rd_en_i) begin
      for (int g = 0; g < int'(N_GRP); g++) begin
        if (en_hit && en_rel == OFF_W'(g))   rdata_o = en_q[32*g +: 32];
        if (raw_hit && raw_rel == OFF_W'(g)) rdata_o = raw_q[32*g +: 32];
        if (bo_hit && bo_rel == OFF_W'(g))   rdata_o = bnc_q[g];
        for (int c = 0; c < int'(N_CPU); c++)
          if (isr_hit && isr_rel == OFF_W'(g) && req_id_i == CPU_W'(c))
            rdata_o = isr_q[c][32*g +: 32];
      end
      for (int w = 0; w < int'(N_PMW); w++)
        if (pm_hit && pm_rel == OFF_W'(w)) rdata_o = pmap_q[w];
      for (int w = 0; w < int'(N_CMW); w++)
        if (cm_hit && cm_rel == OFF_W'(w)) rdata_o = cmap_q[w];
      for (int w = 0; w < int'(N_NODE); w++)
        if (nd_hit && nd_rel == OFF_W'(w)) rdata_o = node_q[w];
    end
  end
endmodule

// File: rtl/xirq_router_chk.sv
module xirq_router_chk #(
  parameter int unsigned N_SRC = 64,
  parameter int unsigned N_CPU = 4,
  parameter int unsigned CPU_W = 2
) (
  input logic                        clk_i,
  input logic                        rst_ni,
  input logic [N_SRC-1:0]            src_i,
  input logic                        rd_en_i,
  input logic [31:0]                 rdata_o,
  input logic [N_CPU*4-1:0]          irq_o,
  input logic [N_SRC-1:0]            raw_q,
  input logic [N_SRC-1:0]            en_q,
  input logic [N_CPU-1:0][N_SRC-1:0] isr_q,
  input logic [N_SRC-1:0][CPU_W-1:0] core_idx
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;

  a_r1_raw_tracks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> raw_q == $past(src_i));

  a_r8_idle_read_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_en_i |-> rdata_o == 32'h0);

  for (genvar c = 0; c < N_CPU; c++) begin : g_cpu
    a_r3_pin_has_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (|irq_o[c*4 +: 4]) |-> (|isr_q[c]));
    for (genvar s = 0; s < N_SRC; s++) begin : g_src
      a_r2_isr_live: assert property (@(posedge clk_i) disable iff (!rst_ni)
        isr_q[c][s] |-> (raw_q[s] && en_q[s] && core_idx[s] == CPU_W'(c)));
    end
  end

  for (genvar s = 0; s < N_SRC; s++) begin : g_own
    logic [N_CPU-1:0] col;
    for (genvar c = 0; c < N_CPU; c++) begin : g_c
      assign col[c] = isr_q[c][s];
    end
    a_r9_single_owner: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $onehot0(col));
  end
endmodule

bind xirq_router xirq_router_chk #(.N_SRC(N_SRC), .N_CPU(N_CPU), .CPU_W(CPU_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .src_i   (src_i),
  .rd_en_i (rd_en_i),
  .rdata_o (rdata_o),
  .irq_o   (irq_o),
  .raw_q   (raw_q),
  .en_q    (en_q),
  .isr_q   (isr_q),
  .core_idx(core_idx)
);

// File: tb/tb_xirq_router.sv
`timescale 1ns/1ps
module tb_xirq_router;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [63:0] src_i = '0;
  logic        wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [11:0] off_i = '0;
  logic [31:0] wdata_i = '0;
  logic [1:0]  req_id_i = '0;
  logic [31:0] rdata_o;
  logic [15:0] irq_o;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  xirq_router dut (.*);

  // {src, expected irq}
  localparam logic [79:0] VEC [10] = '{
    {64'h0,                   16'h0000},
    {64'h1,                   16'h0002},
    {64'h3,                   16'h0202},
    {64'h6,                   16'h2200},
    {64'h50,                  16'h0020},
    {64'h0000_0001_0000_0000, 16'h0100},
    {64'h0000_0100_0000_0000, 16'h0000},
    {64'h0000_0002_0000_0020, 16'h0003},
    {64'h80,                  16'h0002},
    {64'h0,                   16'h0000}
  };

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] off, logic [31:0] d, logic [1:0] req);
    off_i = off; wdata_i = d; req_id_i = req; wr_en_i = 1'b1;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] off, logic [1:0] req, output logic [31:0] d);
    off_i = off; req_id_i = req; rd_en_i = 1'b1;
    #0.5;
    d = rdata_o;
    rd_en_i = 1'b0;
  endtask

  task automatic drive(logic [63:0] v);
    src_i = v;
    @(negedge clk_i);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    // R11 reset state
    check("R11 irq", 64'(irq_o), 64'h0);
    rd(12'h000, 2'd0, d); check("R11 enable", 64'(d), 64'h0);
    rd(12'h100, 2'd0, d); check("R11 coremap", 64'(d), 64'h0);
    rd(12'h040, 2'd0, d); check("R11 raw", 64'(d), 64'h0);

    wr(12'h000, 32'hFFFF_FFFF, 2'd0);
    wr(12'h001, 32'h0000_00FF, 2'd0);
    wr(12'h0C0, 32'h0000_3002, 2'd0);
    wr(12'h100, 32'h0008_0401, 2'd0);
    wr(12'h101, 32'h8006_1002, 2'd0);
    wr(12'h108, 32'h0000_0004, 2'd0);

    // R2 R3 R4 R5 R1 table walk
    for (int i = 0; i < 10; i++) begin
      drive(VEC[i][79:16]);
      check("R2/R3/R4/R5 table irq", 64'(irq_o), 64'(VEC[i][15:0]));
      rd(12'h040, 2'd0, d); check("R1 raw g0", 64'(d), 64'(VEC[i][47:16]));
      rd(12'h041, 2'd0, d); check("R1 raw g1", 64'(d), 64'(VEC[i][79:48]));
    end

    // R3 shared pin
    drive(64'h9);  check("R3 two sources", 64'(irq_o), 64'h2);
    drive(64'h8);  check("R3 one left", 64'(irq_o), 64'h2);
    drive(64'h0);  check("R3 last falls", 64'(irq_o), 64'h0);

    // R6 enable replay, R2 disabled rise
    drive(64'h0000_0100_0000_0000);
    check("R2 disabled rise irq", 64'(irq_o), 64'h0);
    rd(12'h081, 2'd0, d); check("R2 disabled rise isr", 64'(d), 64'h0);
    wr(12'h001, 32'h0000_01FF, 2'd0);
    check("R6 enable raises", 64'(irq_o), 64'h1);
    rd(12'h081, 2'd0, d); check("R6 isr set", 64'(d), 64'h100);
    wr(12'h001, 32'h0000_00FF, 2'd0);
    check("R6 disable withdraws", 64'(irq_o), 64'h0);
    rd(12'h081, 2'd0, d); check("R6 isr clear", 64'(d), 64'h0);
    drive(64'h0);

    // R7 R8 acknowledge per requester
    drive(64'h2); check("R7 raise core2", 64'(irq_o), 64'h0200);
    rd(12'h080, 2'd2, d); check("R8 own copy", 64'(d), 64'h2);
    rd(12'h080, 2'd0, d); check("R8 other copy", 64'(d), 64'h0);
    wr(12'h080, 32'h2, 2'd0);
    check("R7 foreign ack ignored", 64'(irq_o), 64'h0200);
    wr(12'h080, 32'h2, 2'd2);
    check("R7 ack lowers", 64'(irq_o), 64'h0);
    @(negedge clk_i);
    check("R7 no re-raise", 64'(irq_o), 64'h0);
    drive(64'h0);

    // R9 retarget
    drive(64'h8); check("R9 before move", 64'(irq_o), 64'h2);
    wr(12'h100, 32'h0208_0401, 2'd0);
    check("R9 moved", 64'(irq_o), 64'h0020);
    rd(12'h080, 2'd1, d); check("R9 new core isr", 64'(d), 64'h8);
    rd(12'h080, 2'd0, d); check("R9 old core isr", 64'(d), 64'h0);
    drive(64'h0);
    wr(12'h100, 32'h0008_0401, 2'd0);
    check("R9 idle remap", 64'(irq_o), 64'h0);
    rd(12'h100, 2'd0, d); check("R5 readback", 64'(d), 64'h0008_0401);
    drive(64'h8); check("R9 map updated", 64'(irq_o), 64'h2);
    drive(64'h0);

    // R4 pin decode
    wr(12'h0C0, 32'h0000_300C, 2'd0);
    drive(64'h1); check("R4 pin2", 64'(irq_o), 64'h4);
    drive(64'h0);
    wr(12'h0C0, 32'h0000_3000, 2'd0);
    drive(64'h1); check("R4 empty byte pin0", 64'(irq_o), 64'h1);
    drive(64'h0);
    wr(12'h0C0, 32'h0000_0800, 2'd0);
    drive(64'h0000_0001_0000_0000); check("R4 group1 pin3", 64'(irq_o), 64'h0800);
    drive(64'h0);

    // R10 storage only
    wr(12'h201, 32'hDEAD_BEEF, 2'd0);
    wr(12'h243, 32'h1234_5678, 2'd0);
    rd(12'h201, 2'd0, d); check("R10 bounce", 64'(d), 64'hDEAD_BEEF);
    rd(12'h243, 2'd3, d); check("R10 node", 64'(d), 64'h1234_5678);
    check("R10 pins quiet", 64'(irq_o), 64'h0);

    // R8 idle read
    off_i = 12'h201; #0.5;
    check("R8 idle rdata", 64'(rdata_o), 64'h0);

    finish_run();
  end
endmodule